// File: doc/BRIEF.md
# Floating-Point Control and Sticky Status Registers

This block keeps the two configuration words of a small floating-point unit. The control word holds the rounding-mode field. The block drives that field to the arithmetic datapath on every cycle. The status word holds five exception flags. The flags collect results from the datapath and stay set until software overwrites them.

Software writes each word through its own write port and reads either word through one read port. Bits that must be zero are stripped from a write. The write is still applied, and a one-cycle warning pulse tells the surrounding core that the write was out of range. A legacy control write variant keeps the high part of the word and clears only the gap between the rounding field and the high part.

The datapath reports each finished operation with a strobe and a five-bit flag vector. The block merges that vector into the stored flags.

Top module: `fpcsr_top`

## Requirements
- R1: After reset, both words read as zero, `round_mode` is 0 (nearest-even) and `mbz_warn` is low.
- R2: `round_mode` equals bits 1:0 of the stored control word, from the cycle after the control write. The encoding is: 0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity.
- R3: A normal control write (`ctl_wr_legacy`=0) stores bits 6:0 of the data and clears bits 31:7.
- R4: A legacy control write (`ctl_wr_legacy`=1) stores every data bit except bits 11:7, which are cleared.
- R5: A status write stores only data bits 11:7. A status read returns the flags in bits 11:7, in this order: inexact bit 7, underflow bit 8, overflow bit 9, divide-by-zero bit 10, invalid bit 11. All other bits read as zero.
- R6: `mbz_warn` is high for exactly the cycle after one of these writes: a normal control write or a status write whose data has any of bits 31:12 set. The masked write still takes effect. A legacy control write never raises the warning.
- R7: When `op_done` is high, `op_flags` (same bit order as R5, bit 0 = inexact) is OR-ed into the stored flags. Set flags stay set. When `op_done` is low, `op_flags` has no effect.
- R8: When a status write and `op_done` occur in the same cycle, the stored flags become the written flags OR `op_flags`.
- R9: `rd_data` shows the control word when `rd_sel`=0 and the status word when `rd_sel`=1. It follows `rd_sel` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr_en | input | 1 | Control word write strobe |
| ctl_wr_legacy | input | 1 | Selects the legacy control write mask |
| ctl_wr_data | input | 32 | Control write data |
| sts_wr_en | input | 1 | Status word write strobe |
| sts_wr_data | input | 32 | Status write data |
| rd_sel | input | 1 | Read select: 0 control, 1 status |
| rd_data | output | 32 | Read data |
| op_done | input | 1 | Datapath operation-complete strobe |
| op_flags | input | 5 | Exception flags of the completed operation |
| round_mode | output | 2 | Current rounding mode to the datapath |
| mbz_warn | output | 1 | Must-be-zero write warning pulse |

## Verification
The properties assume that every input is a known value on each clock edge while reset is released. They also assume that the datapath flag vector only matters when its strobe is high, so the properties never reason about `op_flags` on other cycles. The stimulus drives every input on the falling edge, away from the capture edge. It keeps all inputs defined from time zero and randomizes `op_flags` even when `op_done` is low, so that R7's ignore rule is exercised. Write data is mostly confined to bits 11:0, with occasional full-width values, so both the clean path and the warning path of R6 occur often.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
    localparam int DATA_W   = 32;
    localparam int NFLAGS   = 5;
    localparam int FLAG_LSB = 7;
    localparam int KEEP_W   = FLAG_LSB;
    localparam int MBZ_LSB  = FLAG_LSB + NFLAGS;
    localparam int RND_W    = 2;

    typedef enum logic [RND_W-1:0] {
        RND_NEAR_EVEN = 2'd0,
        RND_ZERO      = 2'd1,
        RND_POS_INF   = 2'd2,
        RND_NEG_INF   = 2'd3
    } rnd_mode_e;

    typedef enum logic {
        RD_CTL = 1'b0,
        RD_STS = 1'b1
    } rd_sel_e;

    localparam logic [DATA_W-1:0] NORM_KEEP =
        {{(DATA_W-KEEP_W){1'b0}}, {KEEP_W{1'b1}}};
    localparam logic [DATA_W-1:0] GAP_BITS =
        {{(DATA_W-MBZ_LSB){1'b0}}, {(MBZ_LSB-KEEP_W){1'b1}}, {KEEP_W{1'b0}}};
    localparam logic [DATA_W-1:0] LEGACY_KEEP = ~GAP_BITS;
    localparam logic [DATA_W-1:0] MBZ_BITS =
        {{(DATA_W-MBZ_LSB){1'b1}}, {MBZ_LSB{1'b0}}};
endpackage

// File: rtl/fpcsr_ctl_reg.sv
module fpcsr_ctl_reg
    import fpcsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_legacy,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] ctl_q,
    output logic              mbz_hit,
    output rnd_mode_e         mode
);
    logic [DATA_W-1:0] ctl_d;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            if (wr_legacy) ctl_d = wr_data & LEGACY_KEEP;
            else           ctl_d = wr_data & NORM_KEEP;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // Legacy writes own the upper bits, so only normal writes can hit them.
    assign mbz_hit = wr_en && !wr_legacy && ((wr_data & MBZ_BITS) != '0);

    always_comb begin
        unique case (ctl_q[RND_W-1:0])
            2'd0:    mode = RND_NEAR_EVEN;
            2'd1:    mode = RND_ZERO;
            2'd2:    mode = RND_POS_INF;
            default: mode = RND_NEG_INF;
        endcase
    end
endmodule

// File: rtl/fpcsr_flag_reg.sv
module fpcsr_flag_reg
    import fpcsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              op_done,
    input  logic [NFLAGS-1:0] op_flags,
    output logic [NFLAGS-1:0] flag_q,
    output logic              mbz_hit
);
    logic [NFLAGS-1:0] base;
    logic [NFLAGS-1:0] flag_d;

    always_comb begin
        base   = wr_en ? wr_data[FLAG_LSB +: NFLAGS] : flag_q;
        flag_d = op_done ? (base | op_flags) : base;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign mbz_hit = wr_en && ((wr_data & MBZ_BITS) != '0);
endmodule

// File: rtl/fpcsr_read_mux.sv
module fpcsr_read_mux
    import fpcsr_pkg::*;
(
    input  rd_sel_e           sel,
    input  logic [DATA_W-1:0] ctl_q,
    input  logic [NFLAGS-1:0] flag_q,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] sts_word;

    genvar gi;
    generate
        for (gi = 0; gi < DATA_W; gi++) begin : g_sts
            if (gi >= FLAG_LSB && gi < MBZ_LSB) begin : g_flag
                assign sts_word[gi] = flag_q[gi-FLAG_LSB];
            end else begin : g_zero
                assign sts_word[gi] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        unique case (sel)
            RD_CTL:  rd_data = ctl_q;
            default: rd_data = sts_word;
        endcase
    end
endmodule

// File: rtl/fpcsr_top.sv
module fpcsr_top
    import fpcsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr_en,
    input  logic              ctl_wr_legacy,
    input  logic [DATA_W-1:0] ctl_wr_data,
    input  logic              sts_wr_en,
    input  logic [DATA_W-1:0] sts_wr_data,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic              op_done,
    input  logic [NFLAGS-1:0] op_flags,
    output logic [RND_W-1:0]  round_mode,
    output logic              mbz_warn
);
    logic [DATA_W-1:0] ctl_q;
    logic [NFLAGS-1:0] flag_q;
    logic              ctl_mbz;
    logic              sts_mbz;
    rnd_mode_e         mode;
    logic              warn_q;

    fpcsr_ctl_reg ctl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ctl_wr_en),
        .wr_legacy (ctl_wr_legacy),
        .wr_data   (ctl_wr_data),
        .ctl_q     (ctl_q),
        .mbz_hit   (ctl_mbz),
        .mode      (mode)
    );

    fpcsr_flag_reg flag_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (sts_wr_en),
        .wr_data  (sts_wr_data),
        .op_done  (op_done),
        .op_flags (op_flags),
        .flag_q   (flag_q),
        .mbz_hit  (sts_mbz)
    );

    fpcsr_read_mux mux_i (
        .sel     (rd_sel_e'(rd_sel)),
        .ctl_q   (ctl_q),
        .flag_q  (flag_q),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) warn_q <= 1'b0;
        else        warn_q <= ctl_mbz | sts_mbz;
    end

    assign mbz_warn   = warn_q;
    assign round_mode = mode;
endmodule

// File: rtl/fpcsr_top_chk.sv
module fpcsr_top_chk
    import fpcsr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_wr_en,
    input logic              ctl_wr_legacy,
    input logic [DATA_W-1:0] ctl_wr_data,
    input logic              sts_wr_en,
    input logic [DATA_W-1:0] sts_wr_data,
    input logic              rd_sel,
    input logic [DATA_W-1:0] rd_data,
    input logic              op_done,
    input logic [NFLAGS-1:0] op_flags,
    input logic [RND_W-1:0]  round_mode,
    input logic              mbz_warn,
    input logic [NFLAGS-1:0] flag_q
);
    // R2
    rnd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr_en |=> round_mode == $past(ctl_wr_data[RND_W-1:0]));

    // R3
    norm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_en && !ctl_wr_legacy && !rd_sel) |=>
            (rd_sel || rd_data[DATA_W-1:KEEP_W] == '0));

    // R5
    sts_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sel |-> (rd_data & ~GAP_BITS) == '0);

    // R6
    mbz_warn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr_en && sts_wr_data[DATA_W-1:MBZ_LSB] != '0) |=> mbz_warn);

    // R6
    legacy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sts_wr_en && (!ctl_wr_en || ctl_wr_legacy)) |=> !mbz_warn);

    // R7
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sts_wr_en |=> (flag_q & $past(flag_q)) == $past(flag_q));

    // R8
    merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr_en && op_done) |=>
            flag_q == ($past(sts_wr_data[FLAG_LSB +: NFLAGS]) | $past(op_flags)));
endmodule

bind fpcsr_top fpcsr_top_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctl_wr_en     (ctl_wr_en),
    .ctl_wr_legacy (ctl_wr_legacy),
    .ctl_wr_data   (ctl_wr_data),
    .sts_wr_en     (sts_wr_en),
    .sts_wr_data   (sts_wr_data),
    .rd_sel        (rd_sel),
    .rd_data       (rd_data),
    .op_done       (op_done),
    .op_flags      (op_flags),
    .round_mode    (round_mode),
    .mbz_warn      (mbz_warn),
    .flag_q        (flag_q)
);

// File: tb/fpcsr_top_tb_top.sv
module fpcsr_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr_en = 1'b0;
    logic        ctl_wr_legacy = 1'b0;
    logic [31:0] ctl_wr_data = '0;
    logic        sts_wr_en = 1'b0;
    logic [31:0] sts_wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic        op_done = 1'b0;
    logic [4:0]  op_flags = '0;
    logic [1:0]  round_mode;
    logic        mbz_warn;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [31:0] m_ctl = '0;
    logic [4:0]  m_flg = '0;
    logic        m_warn = 1'b0;

    always #4 clk = ~clk;

    fpcsr_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_legacy(ctl_wr_legacy), .ctl_wr_data(ctl_wr_data),
        .sts_wr_en(sts_wr_en), .sts_wr_data(sts_wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .op_done(op_done), .op_flags(op_flags),
        .round_mode(round_mode), .mbz_warn(mbz_warn)
    );

    function automatic logic [31:0] ctl_next(logic [31:0] cur, logic en, logic leg, logic [31:0] d);
        if (!en) return cur;
        return leg ? (d & 32'hFFFF_F07F) : (d & 32'h0000_007F);
    endfunction

    function automatic logic [4:0] flg_next(logic [4:0] cur, logic en, logic [31:0] d, logic done, logic [4:0] f);
        logic [4:0] b;
        b = en ? d[11:7] : cur;
        return done ? (b | f) : b;
    endfunction

    function automatic logic warn_next(logic cen, logic leg, logic [31:0] cd, logic sen, logic [31:0] sd);
        return (cen && !leg && cd[31:12] != 0) || (sen && sd[31:12] != 0);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // Sample outputs mid-cycle against the model of the stored state.
    task automatic observe(string tag);
        rd_sel = 1'b0; #1;
        check({tag, " R9 ctl read"}, rd_data, m_ctl);
        rd_sel = 1'b1; #1;
        check({tag, " R5 sts read"}, rd_data, {20'd0, m_flg, 7'd0});
        check({tag, " R2 round_mode"}, {30'd0, round_mode}, {30'd0, m_ctl[1:0]});
        check({tag, " R6 mbz_warn"}, {31'd0, mbz_warn}, {31'd0, m_warn});
    endtask

    task automatic step(logic cen, logic leg, logic [31:0] cd, logic sen, logic [31:0] sd,
                        logic done, logic [4:0] f);
        ctl_wr_en = cen; ctl_wr_legacy = leg; ctl_wr_data = cd;
        sts_wr_en = sen; sts_wr_data = sd; op_done = done; op_flags = f;
        m_warn = warn_next(cen, leg, cd, sen, sd);
        m_ctl  = ctl_next(m_ctl, cen, leg, cd);
        m_flg  = flg_next(m_flg, sen, sd, done, f);
        @(negedge clk);
        ctl_wr_en = 1'b0; sts_wr_en = 1'b0; op_done = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        observe("R1 reset");

        // R2 every rounding encoding
        for (int m = 0; m < 4; m++) begin
            step(1, 0, 32'(m), 0, 0, 0, 0);
            observe("R2 mode");
        end
        // R3 normal write clears upper, warns
        step(1, 0, 32'hFFFF_FFFF, 0, 0, 0, 0);
        observe("R3 normal full");
        // R4 legacy keeps upper, no warn
        step(1, 1, 32'hFFFF_FFFF, 0, 0, 0, 0);
        observe("R4 legacy full");
        // R6 warning lasts one cycle only
        step(0, 0, 0, 0, 0, 0, 0);
        observe("R6 warn drop");
        // R5 each flag position
        for (int b = 0; b < 5; b++) begin
            step(0, 0, 0, 1, 32'h1 << (7 + b), 0, 0);
            observe("R5 flag pos");
        end
        // R6 status write with MBZ bits still applied
        step(0, 0, 0, 1, 32'hA000_0F80, 0, 0);
        observe("R6 sts mbz");
        // R7 sticky OR and ignore without strobe
        step(0, 0, 0, 1, 32'h0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 5'b00101);
        observe("R7 merge");
        step(0, 0, 0, 0, 0, 0, 5'b11010);
        observe("R7 ignore");
        step(0, 0, 0, 0, 0, 1, 5'b00000);
        observe("R7 sticky");
        // R8 write and op together
        step(0, 0, 0, 1, 32'h0000_0100, 1, 5'b10000);
        observe("R8 same cycle");

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] cd, sd;
            cd = ($urandom % 8 == 0) ? $urandom : ($urandom & 32'hFFF);
            sd = ($urandom % 8 == 0) ? $urandom : ($urandom & 32'hFFF);
            step($urandom % 3 == 0, $urandom % 2, cd, $urandom % 4 == 0, sd,
                 $urandom % 2, 5'($urandom));
            observe("R7 random");
        end

        rst_n = 1'b0;
        @(negedge clk);
        m_ctl = '0; m_flg = '0; m_warn = 1'b0;
        rst_n = 1'b1;
        observe("R1 re-reset");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule